// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block decides when the core of a small 8-bit microcontroller must break off into an interrupt handler and which fixed entry address it jumps to. It watches a set of level request lines (two external pins, two timers and a serial port that flags a completed character in either direction). Each source has an enable bit and a priority bit, and one global enable gates every source.

The controller keeps two in-service flags, one for each priority level. A high-priority request may break into a running low-priority handler. A low-priority request never breaks into a high-priority handler, and no request breaks into a handler of its own level. When several requests at the same level arrive together, a fixed source order settles them. A return strobe from the core closes the innermost handler, so a lower-priority request that was held back can then be taken.

Decisions are registered. A request seen at a clock edge produces a one-cycle take pulse, and the vector appears on the output in the cycle after that edge.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `take` is 0, `vec_addr` is 0000h, and both in-service flags `busy_hi` and `busy_lo` are 0.
- R2: A request on source i is taken only when `glb_en` is 1 and `src_en[i]` is 1. Otherwise it has no effect on `take`, `vec_addr` or the in-service flags.
- R3: When an eligible high-priority request (`src_hi[i]`=1) and an eligible low-priority request are pending together and neither level is blocked, the high-priority one is taken.
- R4: Among eligible requests of the same level, the lowest source index wins. Index 0 is external pin 0, 1 is timer 0, 2 is external pin 1, 3 is timer 1 and 4 is the serial port.
- R5: On a take, `vec_addr` becomes 0003h + 8 × index, which gives 0003h, 000Bh, 0013h, 001Bh and 0023h. It holds that value until the next take.
- R6: While only `busy_lo` is set, an eligible high-priority request is taken and sets `busy_hi`, and `busy_lo` stays set.
- R7: While `busy_hi` is set, no request is taken. While `busy_lo` is set, no low-priority request is taken.
- R8: A `reti` pulse clears `busy_hi` if that flag is set before the edge, and clears `busy_lo` otherwise. It acts on the flags as they stand before the edge, in the same edge where a new take may set a flag.
- R9: `take` is high for exactly one cycle, in the cycle after the edge where the request was sampled. At that same edge the in-service flag of the taken level is set. A request that stays high does not retrigger while its level is in service.
- R10: A `reti` pulse while no flag is set changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NSRC | Level request line per source |
| src_en | input | NSRC | Per-source enable |
| src_hi | input | NSRC | Per-source priority, 1 = high |
| glb_en | input | 1 | Global interrupt enable |
| reti | input | 1 | Return-from-interrupt strobe |
| take | output | 1 | One-cycle pulse: jump to vector |
| vec_addr | output | VEC_W | Entry address of the taken source |
| busy_hi | output | 1 | High-priority handler in service |
| busy_lo | output | 1 | Low-priority handler in service |

## Verification
The bench uses the default parameters: five sources, 16-bit vectors, base 0003h and stride 8. With these, every vector in the fixed table appears on the port, and so does the highest index, serial, in both levels. Five sources are few enough that random request, enable and priority patterns often produce simultaneous requests at the same level, and also high requests arriving during low handlers. Return strobes that coincide with a new take occur routinely, so the ordering in R8 is exercised alongside the directed nesting sequence.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int NSRC       = 5,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             glb_en,
  input  logic             reti,
  output logic             take,
  output logic [VEC_W-1:0] vec_addr,
  output logic             busy_hi,
  output logic             busy_lo
);

  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] elig, cand_hi, cand_lo;
  logic            any_hi, any_lo, grant_hi, grant_lo;
  logic [IW-1:0]   idx_hi, idx_lo, idx_win;
  logic [VEC_W-1:0] vec_next;

  assign elig    = req & src_en & {NSRC{glb_en}};
  assign cand_hi = elig & src_hi;
  assign cand_lo = elig & ~src_hi;

  always_comb begin
    any_hi = 1'b0;
    any_lo = 1'b0;
    idx_hi = '0;
    idx_lo = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand_hi[i]) begin
        any_hi = 1'b1;
        idx_hi = IW'(i);
      end
      if (cand_lo[i]) begin
        any_lo = 1'b1;
        idx_lo = IW'(i);
      end
    end
  end

  assign grant_hi = any_hi && !busy_hi;
  assign grant_lo = !grant_hi && any_lo && !busy_hi && !busy_lo;
  assign idx_win  = grant_hi ? idx_hi : idx_lo;
  assign vec_next = VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(idx_win);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take     <= 1'b0;
      vec_addr <= '0;
      busy_hi  <= 1'b0;
      busy_lo  <= 1'b0;
    end else begin
      take <= grant_hi || grant_lo;
      if (grant_hi || grant_lo) vec_addr <= vec_next;
      if (reti) begin
        if (busy_hi) busy_hi <= 1'b0;
        else         busy_lo <= 1'b0;
      end
      if (grant_hi) busy_hi <= 1'b1;
      if (grant_lo) busy_lo <= 1'b1;
    end
  end

  p_take_needs_glb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(glb_en));

  p_no_take_in_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_hi |=> !take);

  p_hi_rise_on_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_hi) |-> take);

  p_lo_rise_only_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_lo) |-> (take && !busy_hi));

  p_reti_clears_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && busy_hi) |=> !busy_hi);

  p_lo_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_lo && !(reti && !busy_hi)) |=> busy_lo);

  p_vec_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> $stable(vec_addr));

endmodule

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;
  localparam int PERIOD = 10;
  localparam int N = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req = '0, src_en = '0, src_hi = '0;
  logic glb_en = 1'b0, reti = 1'b0;
  logic take, busy_hi, busy_lo;
  logic [15:0] vec_addr;

  int checks = 0, failures = 0;
  bit done = 0;

  logic m_take = 1'b0, m_hi = 1'b0, m_lo = 1'b0;
  logic [15:0] m_vec = '0;

  irq_nest_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req(req), .src_en(src_en), .src_hi(src_hi),
    .glb_en(glb_en), .reti(reti), .take(take), .vec_addr(vec_addr),
    .busy_hi(busy_hi), .busy_lo(busy_lo)
  );

  always #(PERIOD/2) clk = ~clk;

  // returns -1 for no take, else index + 8 when high level
  function automatic int pick(logic [N-1:0] r, logic [N-1:0] e, logic [N-1:0] h,
                              logic g, logic bh, logic bl);
    if (!g || bh) return -1;
    for (int i = 0; i < N; i++) if (r[i] && e[i] && h[i]) return i + 8;
    if (bl) return -1;
    for (int i = 0; i < N; i++) if (r[i] && e[i] && !h[i]) return i;
    return -1;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [N-1:0] r, logic [N-1:0] e, logic [N-1:0] h,
                       logic g, logic rt, string tag);
    int p;
    req = r; src_en = e; src_hi = h; glb_en = g; reti = rt;
    p = pick(r, e, h, g, m_hi, m_lo);
    if (rt) begin
      if (m_hi) m_hi = 1'b0; else m_lo = 1'b0;
    end
    m_take = (p >= 0);
    if (p >= 8) m_hi = 1'b1;
    else if (p >= 0) m_lo = 1'b1;
    if (p >= 0) m_vec = 16'(3 + 8 * (p % 8));
    @(negedge clk);
    chk({tag, " take"}, {15'd0, take}, {15'd0, m_take});
    chk({tag, " vec"}, vec_addr, m_vec);
    chk({tag, " busy"}, {14'd0, busy_hi, busy_lo}, {14'd0, m_hi, m_lo});
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 take", {15'd0, take}, 16'd0);
    chk("R1 vec", vec_addr, 16'h0000);
    chk("R1 busy", {14'd0, busy_hi, busy_lo}, 16'd0);

    drive(5'b11111, 5'b11111, 5'b00000, 1'b0, 1'b0, "R2 glb off");
    chk("R2 no take glb", {15'd0, take}, 16'd0);
    drive(5'b11111, 5'b00000, 5'b00000, 1'b1, 1'b0, "R2 en off");
    chk("R2 no take en", {15'd0, take}, 16'd0);
    drive(5'b10100, 5'b11111, 5'b10000, 1'b1, 1'b0, "R3 hi first");
    chk("R3 R5 vec serial", vec_addr, 16'h0023);
    chk("R3 busy_hi", {15'd0, busy_hi}, 16'd1);
    drive(5'b00110, 5'b11111, 5'b10000, 1'b1, 1'b0, "R7 lo blocked");
    chk("R7 no take under hi", {15'd0, take}, 16'd0);
    drive(5'b00110, 5'b11111, 5'b10000, 1'b1, 1'b1, "R8 reti hi");
    chk("R8 hi cleared", {14'd0, busy_hi, busy_lo}, 16'd0);
    drive(5'b00110, 5'b11111, 5'b10000, 1'b1, 1'b0, "R4 order");
    chk("R4 R5 vec timer0", vec_addr, 16'h000B);
    drive(5'b00100, 5'b11111, 5'b10000, 1'b1, 1'b0, "R7 same level");
    chk("R7 no take same level", {15'd0, take}, 16'd0);
    drive(5'b01000, 5'b11111, 5'b01000, 1'b1, 1'b0, "R6 preempt");
    chk("R6 vec timer1", vec_addr, 16'h001B);
    chk("R6 both busy", {14'd0, busy_hi, busy_lo}, 16'd3);
    drive(5'b00000, 5'b11111, 5'b01000, 1'b1, 1'b1, "R8 inner");
    chk("R8 only lo left", {14'd0, busy_hi, busy_lo}, 16'd1);
    drive(5'b00000, 5'b11111, 5'b01000, 1'b1, 1'b1, "R8 outer");
    chk("R8 none left", {14'd0, busy_hi, busy_lo}, 16'd0);
    drive(5'b00000, 5'b11111, 5'b01000, 1'b1, 1'b1, "R10 idle reti");
    chk("R10 unchanged", {14'd0, busy_hi, busy_lo}, 16'd0);
    drive(5'b00001, 5'b11111, 5'b00000, 1'b1, 1'b0, "R9 pulse on");
    chk("R9 take high", {15'd0, take}, 16'd1);
    chk("R5 vec ext0", vec_addr, 16'h0003);
    drive(5'b00001, 5'b11111, 5'b00000, 1'b1, 1'b0, "R9 pulse off");
    chk("R9 take drops", {15'd0, take}, 16'd0);
    drive(5'b00000, 5'b11111, 5'b00000, 1'b1, 1'b1, "R8 close");

    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] r, e, h;
      r = N'($urandom);
      e = N'($urandom) | N'($urandom);
      h = N'($urandom) & N'($urandom);
      drive(r, e, h, ($urandom % 8) != 0, ($urandom % 4) == 0, "R2-R8 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule